// File: doc/BRIEF.md
# Graphics DMA Channel Mode Sequencer

This block is the control sequencer of a single DMA channel that feeds a graphics device. When software kicks the channel, the sequencer looks at the full channel control word, the block control word and the start address. It picks one of three transfer kinds: device-to-memory block, memory-to-device block, or a linked-list chain. It then holds the channel busy until a completion interrupt is due. The moving of data and the arbitration for memory belong to other blocks; this one only decides what kind of transfer runs and how long it stays open.

For the two block kinds, the transfer length in 32-bit words is the product of the two 16-bit halves of the block control word. For the chain kind, the sequencer asks an external list walker for the total size of the list, starting at the word-aligned start address, and waits for its answer. In every case the completion fires a number of clock cycles equal to the word count after the length becomes known. At that point the start/busy bit (bit 24) of the control word is cleared and a one-cycle interrupt pulse is raised.

Top module: `gfx_dma_seq`

## Requirements
- R1: After synchronous reset, `busy`, `irq` and `walk_req` are low, and `ctl_out` and `mode_out` are zero.
- R2: On an accepted kick, `mode_out` gets the transfer kind and holds it until the next accepted kick. The kinds are 1 for control word 0x01000200 (device to memory), 2 for 0x01000201 (memory to device) and 3 for 0x01000401 (chain).
- R3: In both block kinds the word count N is `blk_in[31:16]` times `blk_in[15:0]`. `irq` is first seen high after the N-th rising edge that follows the edge that accepted the kick.
- R4: A block transfer whose product is zero completes on the first rising edge after the accepting edge.
- R5: In chain kind, `walk_req` is high from the accepting edge until the edge that samples `walk_valid` high. `walk_addr` holds `addr_in` with its two low bits cleared. No `irq` occurs while the sequencer waits.
- R6: In chain kind, `irq` is first seen high after the `walk_len`-th rising edge following the edge that sampled `walk_valid` high. A `walk_len` of zero behaves like one.
- R7: A kick carrying any other control word starts nothing. `busy` stays low, no `irq` follows, and `ctl_out` and `mode_out` keep their values.
- R8: Completion makes `irq` high for exactly one cycle. On the same edge `busy` falls and `ctl_out` bit 24 clears, while every other bit of `ctl_out` keeps the value of the accepted control word.
- R9: A kick while `busy` is high is ignored. The running transfer keeps its length, kind and control word.
- R10: The delay counter is 32 bits wide, so word counts above 65535 run to their full length without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick | input | 1 | Start request, sampled with the three register inputs |
| addr_in | input | 24 | Start address of the transfer |
| blk_in | input | 32 | Block control word: count of blocks (upper half), words per block (lower half) |
| ctl_in | input | 32 | Channel control word |
| walk_len | input | 32 | Total list size from the chain walker, in words |
| walk_valid | input | 1 | `walk_len` is valid |
| walk_req | output | 1 | Sequencer waits for the chain walker |
| walk_addr | output | 24 | Word-aligned list head address for the walker |
| busy | output | 1 | Channel has a transfer open |
| ctl_out | output | 32 | Accepted control word with bit 24 cleared at completion |
| mode_out | output | 2 | Kind of the last accepted transfer |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The bench measures the exact edge count from acceptance to interrupt, for small, non-square and above-16-bit block products. An off-by-one timer, a truncated or swapped product, or a 16-bit counter would each shift or shorten that count. It tests a zero product and a zero list length, where a naive down-counter would wrap and hang. It holds the walker's answer back for several cycles, and a design that ran ahead or fired early would be caught. It also presents near-miss control words and a mid-transfer kick; a partial decode or an unguarded restart would start, lengthen or relabel a transfer.

// File: rtl/gds_pkg.sv
package gds_pkg;

    typedef enum logic [1:0] {
        XFER_NONE    = 2'd0,
        XFER_DEV2MEM = 2'd1,
        XFER_MEM2DEV = 2'd2,
        XFER_CHAIN   = 2'd3
    } xfer_mode_e;

    localparam int CTL_W    = 32;
    localparam int BUSY_BIT = 24;

    localparam logic [CTL_W-1:0] CW_DEV2MEM = 32'h0100_0200;
    localparam logic [CTL_W-1:0] CW_MEM2DEV = 32'h0100_0201;
    localparam logic [CTL_W-1:0] CW_CHAIN   = 32'h0100_0401;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WALK = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_e;

    // Exact full-word match; anything else yields XFER_NONE.
    function automatic xfer_mode_e decode_ctl(input logic [CTL_W-1:0] cw);
        xfer_mode_e m;
        case (cw)
            CW_DEV2MEM: m = XFER_DEV2MEM;
            CW_MEM2DEV: m = XFER_MEM2DEV;
            CW_CHAIN:   m = XFER_CHAIN;
            default:    m = XFER_NONE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/gds_decode.sv
module gds_decode
    import gds_pkg::*;
#(
    parameter int BLK_W = 32,
    parameter int CNT_W = 32
) (
    input  logic [CTL_W-1:0] ctl,
    input  logic [BLK_W-1:0] blk,
    output xfer_mode_e       mode,
    output logic [CNT_W-1:0] words
);
    localparam int HALF_W = BLK_W / 2;
    localparam int PROD_W = 2 * HALF_W;

    logic [HALF_W-1:0] n_blocks;
    logic [HALF_W-1:0] blk_words;
    logic [PROD_W-1:0] product;

    assign n_blocks  = blk[BLK_W-1 -: HALF_W];
    assign blk_words = blk[HALF_W-1:0];
    assign product   = {{HALF_W{1'b0}}, n_blocks} * {{HALF_W{1'b0}}, blk_words};
    assign mode      = decode_ctl(ctl);
    assign words     = CNT_W'(product);

    initial begin
        assert (CNT_W >= PROD_W)
            else $error("assert_cnt_width_R10: counter narrower than product");
    end
endmodule

// File: rtl/gds_timer.sv
module gds_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             running,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    // A value of 0 or 1 both finish on the first edge after loading.
    assign expire  = run_q && (cnt_q <= CNT_W'(1));
    assign running = run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= load_val;
            run_q <= 1'b1;
        end else if (expire) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Each running cycle takes exactly one off the remaining count.
    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (run_q && !expire && !load) |=> (run_q && cnt_q == $past(cnt_q) - CNT_W'(1)));

    assert_load_starts_R6: assert property (@(posedge clk) disable iff (rst)
        load |=> run_q);
endmodule

// File: rtl/gfx_dma_seq.sv
module gfx_dma_seq
    import gds_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int BLK_W  = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              kick,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [BLK_W-1:0]  blk_in,
    input  logic [31:0]       ctl_in,
    input  logic [CNT_W-1:0]  walk_len,
    input  logic              walk_valid,
    output logic              walk_req,
    output logic [ADDR_W-1:0] walk_addr,
    output logic              busy,
    output logic [31:0]       ctl_out,
    output logic [1:0]        mode_out,
    output logic              irq
);
    localparam int ALIGN_B = 2;

    seq_state_e        state_q;
    xfer_mode_e        dec_mode;
    xfer_mode_e        mode_q;
    logic [CNT_W-1:0]  dec_words;
    logic [CNT_W-1:0]  load_val;
    logic [31:0]       ctl_q;
    logic [ADDR_W-1:0] head_q;
    logic              irq_q;
    logic              accept;
    logic              walk_done;
    logic              tmr_load;
    logic              tmr_running;
    logic              tmr_expire;

    gds_decode #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_decode (
        .ctl   (ctl_in),
        .blk   (blk_in),
        .mode  (dec_mode),
        .words (dec_words)
    );

    assign accept    = kick && (state_q == SEQ_IDLE) && (dec_mode != XFER_NONE);
    assign walk_done = (state_q == SEQ_WALK) && walk_valid;
    assign tmr_load  = (accept && dec_mode != XFER_CHAIN) || walk_done;
    assign load_val  = walk_done ? walk_len : dec_words;

    gds_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (load_val),
        .running  (tmr_running),
        .expire   (tmr_expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            mode_q  <= XFER_NONE;
            ctl_q   <= '0;
            head_q  <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= tmr_expire;
            case (state_q)
                SEQ_IDLE: if (accept) begin
                    mode_q  <= dec_mode;
                    ctl_q   <= ctl_in;
                    head_q  <= {addr_in[ADDR_W-1:ALIGN_B], {ALIGN_B{1'b0}}};
                    state_q <= (dec_mode == XFER_CHAIN) ? SEQ_WALK : SEQ_RUN;
                end
                SEQ_WALK: if (walk_valid) state_q <= SEQ_RUN;
                SEQ_RUN: if (tmr_expire) begin
                    state_q         <= SEQ_IDLE;
                    ctl_q[BUSY_BIT] <= 1'b0;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign walk_req  = (state_q == SEQ_WALK);
    assign walk_addr = head_q;
    assign busy      = (state_q != SEQ_IDLE);
    assign ctl_out   = ctl_q;
    assign mode_out  = mode_q;
    assign irq       = irq_q;

    assert_irq_single_R8: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    assert_irq_idle_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (!busy && !ctl_out[BUSY_BIT]));

    assert_walk_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (walk_req && !walk_valid) |=> (walk_req && !irq));

    assert_bad_word_R7: assert property (@(posedge clk) disable iff (rst)
        (kick && !busy && dec_mode == XFER_NONE && !tmr_running) |=> !busy);

    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(mode_out) && $stable({ctl_out[31:BUSY_BIT+1], ctl_out[BUSY_BIT-1:0]})));

    assert_run_timer_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_RUN) |-> tmr_running);
endmodule

// File: tb/gfx_dma_seq_tb_top.sv
`timescale 1ns/1ps
module gfx_dma_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        kick = 1'b0;
    logic [23:0] addr_in = '0;
    logic [31:0] blk_in = '0;
    logic [31:0] ctl_in = '0;
    logic [31:0] walk_len = '0;
    logic        walk_valid = 1'b0;
    logic        walk_req;
    logic [23:0] walk_addr;
    logic        busy;
    logic [31:0] ctl_out;
    logic [1:0]  mode_out;
    logic        irq;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    gfx_dma_seq dut_i (
        .clk(clk), .rst(rst), .kick(kick), .addr_in(addr_in), .blk_in(blk_in),
        .ctl_in(ctl_in), .walk_len(walk_len), .walk_valid(walk_valid),
        .walk_req(walk_req), .walk_addr(walk_addr), .busy(busy),
        .ctl_out(ctl_out), .mode_out(mode_out), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Kick held over one edge (the accepting edge); returns 1ns after it.
    task automatic kick_once(input logic [31:0] cw, input logic [31:0] bw, input logic [23:0] a);
        @(negedge clk);
        ctl_in = cw; blk_in = bw; addr_in = a; kick = 1'b1;
        @(posedge clk); #1;
        kick = 1'b0;
    endtask

    // Counts edges until irq is seen high.
    task automatic wait_irq(output int n, input int limit);
        n = 0;
        do begin
            @(posedge clk); #1;
            n++;
        end while (!irq && n < limit);
    endtask

    task automatic finish_checks(input logic [31:0] cw, input string tag);
        check(!busy, {tag, " busy low at irq"}, busy, 0);
        check(ctl_out == (cw & ~32'h0100_0000), {tag, " ctl bit24 cleared"}, ctl_out, cw & ~32'h0100_0000);
        @(posedge clk); #1;
        check(!irq, {tag, " irq one cycle"}, irq, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        check(!busy && !irq && !walk_req, "R1 outputs low", {busy, irq, walk_req}, 0);
        check(ctl_out == 0 && mode_out == 0, "R1 regs zero", {ctl_out, mode_out}, 0);
    endtask

    task automatic t_block(input logic [31:0] cw, input logic [31:0] bw, input int exp_n,
                           input logic [1:0] exp_mode, input string tag);
        int n;
        kick_once(cw, bw, 24'h000100);
        check(busy, {tag, " busy after accept"}, busy, 1);
        check(mode_out == exp_mode, {tag, " R2 mode"}, mode_out, exp_mode);
        wait_irq(n, exp_n + 20);
        check(n == exp_n, {tag, " latency"}, n, exp_n);
        finish_checks(cw, tag);
    endtask

    task automatic t_chain(input int len, input int exp_n, input string tag);
        int n;
        kick_once(32'h0100_0401, 32'h0, 24'h123457);
        check(walk_req, {tag, " R5 walk_req"}, walk_req, 1);
        check(walk_addr == 24'h123454, {tag, " R5 walk_addr aligned"}, walk_addr, 24'h123454);
        check(mode_out == 2'd3, {tag, " R2 chain mode"}, mode_out, 3);
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            check(walk_req && busy && !irq, {tag, " R5 waiting"}, {walk_req, busy, irq}, 3'b110);
        end
        @(negedge clk);
        walk_len = len; walk_valid = 1'b1;
        @(posedge clk); #1;
        walk_valid = 1'b0;
        check(!walk_req, {tag, " R5 walk_req drops"}, walk_req, 0);
        wait_irq(n, exp_n + 20);
        check(n == exp_n, {tag, " R6 latency"}, n, exp_n);
        finish_checks(32'h0100_0401, tag);
    endtask

    task automatic t_invalid(input logic [31:0] cw, input string tag);
        logic [31:0] c0;
        logic [1:0]  m0;
        c0 = ctl_out; m0 = mode_out;
        kick_once(cw, 32'h0001_0003, 24'h000040);
        for (int i = 0; i < 6; i++) begin
            check(!busy && !irq, {tag, " R7 no start"}, {busy, irq}, 0);
            @(posedge clk); #1;
        end
        check(ctl_out == c0 && mode_out == m0, {tag, " R7 regs kept"}, {ctl_out, mode_out}, {c0, m0});
    endtask

    task automatic t_busy_kick();
        int n;
        kick_once(32'h0100_0200, 32'h0004_0005, 24'h000200);
        n = 0;
        do begin
            @(negedge clk);
            if (n == 3) begin
                ctl_in = 32'h0100_0401; blk_in = 32'h0001_0002; kick = 1'b1;
            end else kick = 1'b0;
            @(posedge clk); #1;
            n++;
        end while (!irq && n < 60);
        kick = 1'b0;
        check(n == 20, "R9 length kept", n, 20);
        check(mode_out == 2'd1, "R9 mode kept", mode_out, 1);
        check(!walk_req, "R9 no walk", walk_req, 0);
        finish_checks(32'h0100_0200, "R9");
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_block(32'h0100_0200, 32'h0003_0004, 12, 2'd1, "R3 dev2mem");
        t_block(32'h0100_0201, 32'h0002_0007, 14, 2'd2, "R3 mem2dev");
        t_block(32'h0100_0201, 32'h0001_0001, 1, 2'd2, "R3 single");
        t_block(32'h0100_0200, 32'h0000_0009, 1, 2'd1, "R4 zero product");
        t_invalid(32'h0100_0202, "R7 near word");
        t_invalid(32'h0000_0201, "R7 no start bit");
        t_chain(7, 7, "R6 chain");
        t_chain(0, 1, "R6 chain zero");
        t_invalid(32'h0100_0400, "R7 chain near");
        t_busy_kick();
        t_block(32'h0100_0201, 32'h0100_0100, 65536, 2'd2, "R10 wide count");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule